// File: doc/BRIEF.md
# Serial-Bus Command Front End for a 256-Step Digital Potentiometer

This block is the two-wire serial slave that sits in front of a 256-step digital potentiometer. It oversamples the bus clock and data lines in the system clock domain and recognises start, repeated-start and stop conditions. It compares the address byte against a 7-bit device address whose low two bits come from strap pins, and it acknowledges through an open-drain pull-down enable. After the address, an instruction byte loads a register pointer that lasts across transactions. Following data bytes then write the wiper, request EEPROM writes or set the write-protect latch. Store and restore commands need only the instruction byte.

Reads return the byte that the pointer selects: the wiper, the EEPROM data presented by an external memory controller, or one of two factory tolerance bytes held in a small read-only array. Because the pointer is kept, a master can skip the pointer write and read the last register directly. A burst read of the two tolerance bytes steps the pointer from the first location to the second.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset the wiper holds 0x80, the SDA pull-down enable is off, and neither strobe output is active.
- R2: The device address is {5'b00110, strap_i[1:0]}, with strap_i sampled on the first clock after reset, and bit 0 of the address byte is R/W (1 = read). On a match the slave pulls SDA low on the ninth clock. On a mismatch it never pulls SDA low and ignores all bytes until the next start.
- R3: The instruction byte is always acknowledged and is stored as the pointer: bits [7:5] are the operation (000 wiper write, 001 EEPROM write, 010 write-protect, 011 memory read, 100 wiper read, 101 store, 110 restore, 111 unused) and bits [4:0] are the location.
- R4: With operation 000, every data byte up to the stop is acknowledged and loaded into the wiper, MSB first.
- R5: With operation 001, every data byte is acknowledged and produces a one-cycle eep_wr_o pulse with the byte on eep_wdata_o.
- R6: With operation 010, bit 0 of each data byte sets (1) or clears (0) write protect. While it is set, wiper writes, EEPROM writes and store are still acknowledged but have no effect.
- R7: Instruction 101 pulses cmd_stb_o with cmd_code_o = 3'b101. Instruction 110 loads eep_rdata_i into the wiper and pulses cmd_stb_o with cmd_code_o = 3'b110. A data byte that follows any operation other than 000, 001 or 010 is not acknowledged.
- R8: A read returns, MSB first, the byte that the pointer selects. Pointer operation 011 with location 5'b11110 gives the tolerance integer byte (default 0x13), 5'b11111 gives the fraction byte (default 0x4D), and any other location gives eep_rdata_i. Operations 001, 101 and 110 also give eep_rdata_i, and all others give the wiper. A read with no preceding pointer write uses the pointer left by the last transaction.
- R9: When the pointer is 011/11110 and the master acknowledges a read byte, the pointer moves to 11111, so the next byte is the fraction byte.
- R10: The SDA enable changes only while SCL is low. A master NACK ends the read and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 2 | Address strap pins, low two address bits |
| eep_rdata_i | input | 8 | Stored EEPROM byte from the memory controller |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wiper_o | output | 8 | Wiper setting |
| eep_wr_o | output | 1 | One-cycle EEPROM write request |
| eep_wdata_o | output | 8 | Byte for the EEPROM write |
| cmd_stb_o | output | 1 | One-cycle store/restore command strobe |
| cmd_code_o | output | 3 | Operation code that goes with cmd_stb_o |

## Verification
Two functions fall in the same cycle at a restore: the wiper reload from eep_rdata_i and the command strobe. The scoreboard queues a wiper event and then a command event, and the monitor must see both at the same sampling point in that order. A second coincidence occurs in a tolerance burst. The pointer advance and the master acknowledge are taken in one cycle, and the byte then reloaded at the next SCL fall must already be the fraction byte. The bench judges this by the value read back on the second byte.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;
  typedef enum logic [2:0] {
    OP_WIPER_WR = 3'b000,
    OP_EEP_WR   = 3'b001,
    OP_WPROT    = 3'b010,
    OP_MEM_RD   = 3'b011,
    OP_WIPER_RD = 3'b100,
    OP_STORE    = 3'b101,
    OP_RESTORE  = 3'b110,
    OP_NONE     = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_SKIP
  } phase_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LOC_W  = 5;
  localparam logic [LOC_W-1:0] LOC_TOL_HI = 5'b11110;
  localparam logic [LOC_W-1:0] LOC_TOL_LO = 5'b11111;
endpackage

// File: rtl/dpot_i2c_sync.sv
module dpot_i2c_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[SYNC_STAGES-1];
  assign sda_s      = sda_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dpot_i2c_link.sv
module dpot_i2c_link
  import dpot_i2c_pkg::*;
#(
  parameter logic [4:0] DEV_ID = 5'b00110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        strap_i,
  input  logic              data_ack_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sda_oe_o,
  output logic              instr_stb_o,
  output logic              wdata_stb_o,
  output logic              rd_adv_stb_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q, oe_q, mack_q, strap_vld_q;
  logic [1:0]        strap_q;
  logic [BYTE_W-1:0] shreg_q, tx_q;
  logic              byte_done, addr_hit;

  assign addr_hit  = (shreg_q[7:1] == {DEV_ID, strap_q});
  assign byte_done = scl_fall_i & ~in_ack_q & (cnt_q == CNT_FULL);

  assign instr_stb_o  = byte_done & (phase_q == PH_INSTR);
  assign wdata_stb_o  = byte_done & (phase_q == PH_WDATA);
  assign rd_adv_stb_o = scl_rise_i & in_ack_q & (phase_q == PH_RDATA) & ~sda_s_i;
  assign rx_byte_o    = shreg_q;
  assign sda_oe_o     = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      in_ack_q    <= 1'b0;
      oe_q        <= 1'b0;
      mack_q      <= 1'b0;
      shreg_q     <= '0;
      tx_q        <= '0;
      strap_q     <= '0;
      strap_vld_q <= 1'b0;
    end else begin
      if (!strap_vld_q) begin
        strap_q     <= strap_i;
        strap_vld_q <= 1'b1;
      end
      if (start_i) begin
        phase_q  <= PH_ADDR;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_i) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        case (phase_q)
          PH_ADDR, PH_INSTR, PH_WDATA: begin
            if (scl_rise_i && !in_ack_q && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (byte_done) begin
              in_ack_q <= 1'b1;
              case (phase_q)
                PH_ADDR:  if (addr_hit) oe_q <= 1'b1; else phase_q <= PH_SKIP;
                PH_INSTR: oe_q <= 1'b1;
                default:  if (data_ack_i) oe_q <= 1'b1; else phase_q <= PH_SKIP;
              endcase
            end else if (scl_fall_i && in_ack_q) begin
              in_ack_q <= 1'b0;
              cnt_q    <= '0;
              oe_q     <= 1'b0;
              if (phase_q == PH_ADDR) begin
                if (shreg_q[0]) begin
                  phase_q <= PH_RDATA;
                  tx_q    <= tx_byte_i;
                  oe_q    <= ~tx_byte_i[BYTE_W-1];
                end else begin
                  phase_q <= PH_INSTR;
                end
              end else if (phase_q == PH_INSTR) begin
                phase_q <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            if (scl_rise_i && !in_ack_q) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && !in_ack_q) begin
              if (cnt_q == CNT_FULL) begin
                oe_q     <= 1'b0;
                in_ack_q <= 1'b1;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end else if (scl_rise_i && in_ack_q) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i && in_ack_q) begin
              in_ack_q <= 1'b0;
              cnt_q    <= '0;
              if (mack_q) begin
                tx_q <= tx_byte_i;
                oe_q <= ~tx_byte_i[BYTE_W-1];
              end else begin
                phase_q <= PH_SKIP;
                oe_q    <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_i2c_regs.sv
module dpot_i2c_regs
  import dpot_i2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WIPER_RST = 8'h80,
  parameter logic [BYTE_W-1:0] TOL_HI    = 8'h13,
  parameter logic [BYTE_W-1:0] TOL_LO    = 8'h4D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_stb_i,
  input  logic              wdata_stb_i,
  input  logic              rd_adv_stb_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] eep_rdata_i,
  output logic              data_ack_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [BYTE_W-1:0] wiper_o,
  output logic              eep_wr_o,
  output logic [BYTE_W-1:0] eep_wdata_o,
  output logic              cmd_stb_o,
  output logic [2:0]        cmd_code_o
);
  op_e               ptr_op_q, in_op;
  logic [LOC_W-1:0]  ptr_loc_q;
  logic              wp_q;
  logic [BYTE_W-1:0] wiper_q, eep_wdata_q, mem_byte;
  logic              eep_wr_q, cmd_stb_q;
  logic [2:0]        cmd_code_q;

  assign in_op = op_e'(rx_byte_i[BYTE_W-1:BYTE_W-3]);

  assign data_ack_o = (ptr_op_q == OP_WIPER_WR) || (ptr_op_q == OP_EEP_WR) ||
                      (ptr_op_q == OP_WPROT);

  always_comb begin
    mem_byte = eep_rdata_i;
    if (ptr_op_q == OP_MEM_RD && ptr_loc_q == LOC_TOL_HI) mem_byte = TOL_HI;
    if (ptr_op_q == OP_MEM_RD && ptr_loc_q == LOC_TOL_LO) mem_byte = TOL_LO;
    case (ptr_op_q)
      OP_MEM_RD, OP_EEP_WR, OP_STORE, OP_RESTORE: tx_byte_o = mem_byte;
      default:                                    tx_byte_o = wiper_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_op_q    <= OP_WIPER_RD;
      ptr_loc_q   <= '0;
      wp_q        <= 1'b0;
      wiper_q     <= WIPER_RST;
      eep_wr_q    <= 1'b0;
      eep_wdata_q <= '0;
      cmd_stb_q   <= 1'b0;
      cmd_code_q  <= '0;
    end else begin
      eep_wr_q  <= 1'b0;
      cmd_stb_q <= 1'b0;
      if (instr_stb_i) begin
        ptr_op_q  <= in_op;
        ptr_loc_q <= rx_byte_i[LOC_W-1:0];
        if (in_op == OP_STORE && !wp_q) begin
          cmd_stb_q  <= 1'b1;
          cmd_code_q <= OP_STORE;
        end
        if (in_op == OP_RESTORE) begin
          cmd_stb_q  <= 1'b1;
          cmd_code_q <= OP_RESTORE;
          wiper_q    <= eep_rdata_i;
        end
      end
      if (wdata_stb_i) begin
        case (ptr_op_q)
          OP_WIPER_WR: if (!wp_q) wiper_q <= rx_byte_i;
          OP_EEP_WR: if (!wp_q) begin
            eep_wr_q    <= 1'b1;
            eep_wdata_q <= rx_byte_i;
          end
          OP_WPROT: wp_q <= rx_byte_i[0];
          default: ;
        endcase
      end
      // tolerance burst: step integer byte -> fraction byte
      if (rd_adv_stb_i && ptr_op_q == OP_MEM_RD && ptr_loc_q == LOC_TOL_HI)
        ptr_loc_q <= LOC_TOL_LO;
    end
  end

  assign wiper_o     = wiper_q;
  assign eep_wr_o    = eep_wr_q;
  assign eep_wdata_o = eep_wdata_q;
  assign cmd_stb_o   = cmd_stb_q;
  assign cmd_code_o  = cmd_code_q;
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_i2c_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [4:0]        DEV_ID      = 5'b00110,
  parameter logic [BYTE_W-1:0] WIPER_RST   = 8'h80,
  parameter logic [BYTE_W-1:0] TOL_HI      = 8'h13,
  parameter logic [BYTE_W-1:0] TOL_LO      = 8'h4D
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  strap_i,
  input  logic [7:0]  eep_rdata_i,
  output logic        sda_oe_o,
  output logic [7:0]  wiper_o,
  output logic        eep_wr_o,
  output logic [7:0]  eep_wdata_o,
  output logic        cmd_stb_o,
  output logic [2:0]  cmd_code_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic instr_stb, wdata_stb, rd_adv_stb, data_ack;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  dpot_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  dpot_i2c_link #(.DEV_ID(DEV_ID)) u_link (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .strap_i, .data_ack_i(data_ack),
    .tx_byte_i(tx_byte), .sda_oe_o, .instr_stb_o(instr_stb),
    .wdata_stb_o(wdata_stb), .rd_adv_stb_o(rd_adv_stb), .rx_byte_o(rx_byte)
  );

  dpot_i2c_regs #(.WIPER_RST(WIPER_RST), .TOL_HI(TOL_HI), .TOL_LO(TOL_LO)) u_regs (
    .clk_i, .rst_ni, .instr_stb_i(instr_stb), .wdata_stb_i(wdata_stb),
    .rd_adv_stb_i(rd_adv_stb), .rx_byte_i(rx_byte), .eep_rdata_i,
    .data_ack_o(data_ack), .tx_byte_o(tx_byte), .wiper_o, .eep_wr_o,
    .eep_wdata_o, .cmd_stb_o, .cmd_code_o
  );
endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [7:0] wiper_o,
  input logic       eep_wr_o,
  input logic       cmd_stb_o,
  input logic [2:0] cmd_code_o
);
  a_r10_oe_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> (sda_oe_o == $past(sda_oe_o)));

  a_r4_wiper_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> !scl_i);

  a_r5_eep_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_wr_o |=> !eep_wr_o);

  a_r7_cmd_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> (cmd_code_o == 3'b101 || cmd_code_o == 3'b110));

  a_r7_cmd_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);

  a_r5_no_eep_with_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eep_wr_o && cmd_stb_o));
endmodule

bind dpot_i2c_slave dpot_i2c_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wiper_o(wiper_o), .eep_wr_o(eep_wr_o), .cmd_stb_o(cmd_stb_o),
  .cmd_code_o(cmd_code_o)
);

// File: tb/dpot_i2c_slave_bench.sv
`timescale 1ns/1ps
module dpot_i2c_slave_bench;
  localparam int Q = 20;
  localparam logic [6:0] DEV = 7'b0011001;
  localparam logic [7:0] AW = {DEV, 1'b0};
  localparam logic [7:0] AR = {DEV, 1'b1};
  localparam logic [7:0] EEP_VAL = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, eep_wr, cmd_stb;
  logic [7:0] wiper, eep_wdata;
  logic [2:0] cmd_code;
  logic sda;
  int n_chk = 0, n_err = 0;

  typedef struct { int kind; int val; string req; } ev_t;
  ev_t exp_q[$];
  logic [7:0] wiper_prev = 8'h80;

  always #4 clk = ~clk;
  assign sda = m_sda & ~sda_oe;

  dpot_i2c_slave u_dpot_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda), .strap_i(2'b01),
    .eep_rdata_i(EEP_VAL), .sda_oe_o(sda_oe), .wiper_o(wiper), .eep_wr_o(eep_wr),
    .eep_wdata_o(eep_wdata), .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int kind, int val, string req);
    ev_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: 0 wiper change, 1 eeprom write, 2 command strobe
  task automatic got(int kind, int val);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL R4 unexpected event kind=%0d actual=%0h expected=none", kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val != val) begin
        n_err++;
        $display("FAIL %s event actual=%0d/%0h expected=%0d/%0h", e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wiper !== wiper_prev) begin got(0, int'(wiper)); wiper_prev = wiper; end
    if (eep_wr) got(1, int'(eep_wdata));
    if (cmd_stb) got(2, int'(cmd_code));
  end

  task automatic qw();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic bit_cell(input logic b, output logic s);
    m_sda = b; qw(); m_scl = 1'b1; qw(); s = sda; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cell(b[i], s);
    bit_cell(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_cell(1'b1, s); d[i] = s; end
    bit_cell(~mack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (5) @(posedge clk); #2;
    chk("R1 wiper", int'(wiper), 8'h80);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 strobes", int'({eep_wr, cmd_stb}), 0);

    // R2: foreign address
    bus_start(); wbyte({7'b0011011, 1'b0}, a); chk("R2 mismatch nack", int'(a), 0);
    wbyte(8'h00, a); chk("R2 ignored instr", int'(a), 0);
    wbyte(8'h44, a); chk("R2 ignored data", int'(a), 0);
    bus_stop(); chk("R2 wiper untouched", int'(wiper), 8'h80);

    // R3/R4: repeated wiper write
    bus_start(); wbyte(AW, a); chk("R2 match ack", int'(a), 1);
    wbyte(8'h00, a); chk("R3 instr ack", int'(a), 1);
    push(0, 8'h35, "R4"); wbyte(8'h35, a); chk("R4 data ack 1", int'(a), 1);
    push(0, 8'h7A, "R4"); wbyte(8'h7A, a); chk("R4 data ack 2", int'(a), 1);
    bus_stop(); chk("R4 wiper", int'(wiper), 8'h7A);

    // R8: read reusing last pointer
    bus_start(); wbyte(AR, a); chk("R8 read addr ack", int'(a), 1);
    rbyte(1'b0, d); bus_stop(); chk("R8 reuse pointer wiper", int'(d), 8'h7A);
    chk("R10 released after nack", int'(sda_oe), 0);

    // R9: tolerance burst with repeated start
    bus_start(); wbyte(AW, a); wbyte({3'b011, 5'b11110}, a);
    bus_start(); wbyte(AR, a); chk("R9 rd addr ack", int'(a), 1);
    rbyte(1'b1, d); chk("R9 tol integer", int'(d), 8'h13);
    rbyte(1'b0, d); chk("R9 tol fraction", int'(d), 8'h4D);
    bus_stop();
    bus_start(); wbyte(AR, a); rbyte(1'b0, d); bus_stop();
    chk("R8 pointer kept at fraction", int'(d), 8'h4D);

    // R8: eeprom location read
    bus_start(); wbyte(AW, a); wbyte({3'b011, 5'b00000}, a);
    bus_start(); wbyte(AR, a); rbyte(1'b0, d); bus_stop();
    chk("R8 eeprom read", int'(d), EEP_VAL);

    // R5: eeprom write
    bus_start(); wbyte(AW, a); wbyte({3'b001, 5'b0}, a);
    push(1, 8'h5C, "R5"); wbyte(8'h5C, a); chk("R5 data ack", int'(a), 1);
    bus_stop();

    // R7: store then data nack
    bus_start(); wbyte(AW, a);
    push(2, 5, "R7"); wbyte({3'b101, 5'b0}, a); chk("R7 store ack", int'(a), 1);
    wbyte(8'h12, a); chk("R7 data after store nack", int'(a), 0);
    bus_stop();

    // R7: restore, wiper and strobe together
    push(0, EEP_VAL, "R7"); push(2, 6, "R7");
    bus_start(); wbyte(AW, a); wbyte({3'b110, 5'b0}, a); bus_stop();
    chk("R7 restore wiper", int'(wiper), EEP_VAL);

    // R6: write protect
    bus_start(); wbyte(AW, a); wbyte({3'b010, 5'b0}, a);
    wbyte(8'h01, a); chk("R6 wp ack", int'(a), 1); bus_stop();
    bus_start(); wbyte(AW, a); wbyte(8'h00, a);
    wbyte(8'h11, a); chk("R6 protected write ack", int'(a), 1); bus_stop();
    bus_start(); wbyte(AR, a); rbyte(1'b0, d); bus_stop();
    chk("R6 wiper held", int'(d), EEP_VAL);
    bus_start(); wbyte(AW, a); wbyte({3'b001, 5'b0}, a); wbyte(8'h66, a); bus_stop();
    bus_start(); wbyte(AW, a); wbyte({3'b101, 5'b0}, a); bus_stop();
    bus_start(); wbyte(AW, a); wbyte({3'b010, 5'b0}, a); wbyte(8'h00, a); bus_stop();
    bus_start(); wbyte(AW, a); wbyte(8'h00, a);
    push(0, 8'h22, "R6"); wbyte(8'h22, a); bus_stop();
    chk("R6 wiper after unprotect", int'(wiper), 8'h22);

    repeat (20) @(posedge clk); #2;
    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule